// File: doc/BRIEF.md
# Disk Controller Command Front End

This block is the host-facing register front end of a floppy-style disk controller. A CPU reaches it through a small read/write bus with three locations. Address 0 is the output control register, which drives the drive select, motor enable and controller-reset lines. Address 1 is a read-only status byte. Address 2 is the byte-wide data port. Every command passes through up to three phases. The host first writes a command byte and its parameter bytes. For head movement there is then an execution phase. Commands that report back then have a result phase, in which the host reads result bytes from the same data port.

The data port has no valid/ready wires. The status byte carries its flow control. The host may move a byte only while the request bit (bit 7) is 1, and the direction bit (bit 6) says which way that byte goes. A host that writes when it should not have its byte dropped and a sticky protocol-error flag set. Seek and Recalibrate report their outcome later, through per-drive pending status that a Sense Interrupt command collects. Releasing the controller from reset leaves one pending status for each of the four drives. These must all be collected before any other command is accepted.

Top module: `flop_cmd_front`

## Requirements
- R1: After the `rst_n` reset, the output control register (address 0) reads 0x00, so the controller is held in reset (`ctl_in_reset`=1), and the status byte (address 1) reads 0x80.
- R2: Handshake in the status byte, which has request at bit 7, direction at bit 6 and busy at bit 4. While parameter bytes are awaited it reads 0x90. In the result phase it reads 0xD0. Reading the last result byte returns it to 0x80.
- R3: During an execution phase, request and direction are 0 and busy is 1. Bits 3:0 hold the one-hot number of the moving drive. Bit 5 is set exactly when the stored no-DMA flag is 1.
- R4: Version (0x10) yields the single result byte 0x90. Any command byte outside the supported set yields the single result byte 0x80.
- R5: Specify (0x03) takes two parameter bytes and has no result phase. Byte 1 is step rate in bits 7:4 and unload time in bits 3:0. Byte 2 is load time in bits 7:1 and no-DMA in bit 0. These appear on `step_rate`, `unload_time`, `load_time` and `no_dma`.
- R6: Configure (0x13) takes three parameter bytes and has no result phase. Byte 1 is ignored. Byte 2 holds implied seek in bit 6, FIFO disable in bit 5 and threshold-minus-one in bits 3:0. Byte 3 is ignored.
- R7: Seek (0x0F) takes the bytes (head<<2 | drive) and the target cylinder. Recalibrate (0x07) takes the byte drive and targets cylinder 0. Neither has a result phase. Execution lasts |target−current|·STEP_CYC+1 cycles after the last parameter. At its end the drive's cylinder is updated and the drive gets pending status ST0 = 0x20 | head<<2 | drive.
- R8: Sense Interrupt (0x08) returns ST0 and then the cylinder of the lowest-numbered drive that has pending status, and clears that drive's pending status. When no drive has pending status, it returns the single byte 0x80.
- R9: Output control register bits: 1:0 select the drive, bit 2 is reset-not, bit 3 is the interrupt enable, and bits 7:4 are the motor enables for drives 3..0. The register reads back unchanged.
- R10: While bit 2 is 0, the controller is held in reset. The held reset clears the Specify values, disables the FIFO, sets the threshold field to 0, zeroes all cylinders, clears the protocol error and aborts any command. Implied seek keeps its value. When bit 2 is set again, all four drives get pending ST0 = 0xC0 | drive with cylinder 0.
- R11: Until those post-reset statuses are all collected, every command other than Sense Interrupt gives the single result byte 0x80 and has no other effect.
- R12: A data-port write made while request is 0 or direction is 1 is ignored and sets `proto_err`. Only a reset clears `proto_err`.
- R13: `irq` equals an internal flag ANDed with control bit 3. The flag sets at the end of execution and at reset release. It clears when a Sense Interrupt command byte is accepted or when any result byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | 0 control register, 1 status, 2 data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (takes effect on the data port only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Completion interrupt |
| drv_sel | output | 2 | Selected drive |
| motor_on | output | 4 | Motor enable per drive |
| ctl_in_reset | output | 1 | Controller held in reset |
| step_rate | output | 4 | Stored step rate |
| unload_time | output | 4 | Stored head unload time |
| load_time | output | 7 | Stored head load time |
| no_dma | output | 1 | Stored no-DMA flag |
| fifo_on | output | 1 | FIFO enabled |
| fifo_thresh | output | 4 | FIFO threshold minus one |
| implied_seek | output | 1 | Implied seek enable |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The end of a seek's execution can fall in the same cycle as a host write that puts the controller into reset. The bench provokes this with a Seek to the drive's current cylinder, which completes one cycle after its last parameter, and follows it at once with a control-register write that clears bit 2. The outcome is correct when, after release, all four drives report the reset status 0xC0|drive with cylinder 0 and no trace of the seek survives. Randomized seeks and recalibrates with a fixed seed are also compared against a bench model of the cylinders, and exact execution lengths are checked.

// File: rtl/flop_cmd_pkg.sv
package flop_cmd_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_PARAM, PH_EXEC, PH_RESULT} phase_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam logic [7:0] OP_SPECIFY = 8'h03;
  localparam logic [7:0] OP_RECAL   = 8'h07;
  localparam logic [7:0] OP_SENSE   = 8'h08;
  localparam logic [7:0] OP_SEEK    = 8'h0F;
  localparam logic [7:0] OP_VERSION = 8'h10;
  localparam logic [7:0] OP_CONFIG  = 8'h13;

  localparam logic [7:0] ID_BYTE  = 8'h90;
  localparam logic [7:0] BAD_BYTE = 8'h80;

  function automatic logic op_known(input logic [7:0] op);
    return op == OP_SPECIFY || op == OP_RECAL || op == OP_SENSE ||
           op == OP_SEEK || op == OP_VERSION || op == OP_CONFIG;
  endfunction

  function automatic logic [1:0] op_params(input logic [7:0] op);
    case (op)
      OP_SPECIFY: return 2'd2;
      OP_SEEK:    return 2'd2;
      OP_CONFIG:  return 2'd3;
      OP_RECAL:   return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/flop_ctrl_reg.sv
module flop_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       hold,
  output logic       arm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 8'h00;
    else if (wr) ctrl_q <= wdata;
  end

  assign hold = !ctrl_q[2];
  // release from reset: bit 2 goes from 0 to 1
  assign arm  = wr && wdata[2] && !ctrl_q[2];

  a_r9_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctrl_q == $past(wdata));
endmodule

// File: rtl/flop_drive_track.sv
module flop_drive_track #(
  parameter int NDRV  = 4,
  parameter int CYL_W = 8,
  localparam int DRV_W = $clog2(NDRV)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    arm,
  input  logic                    done_en,
  input  logic [DRV_W-1:0]        done_drv,
  input  logic [CYL_W-1:0]        done_cyl,
  input  logic [7:0]              done_st0,
  input  logic                    clr_en,
  input  logic [DRV_W-1:0]        clr_drv,
  output logic [NDRV*CYL_W-1:0]   cyl_flat,
  output logic [NDRV*8-1:0]       st0_flat,
  output logic [NDRV-1:0]         pend
);
  for (genvar i = 0; i < NDRV; i++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        cyl_flat[i*CYL_W +: CYL_W] <= '0;
        st0_flat[i*8 +: 8] <= 8'h00;
      end else if (arm) begin
        pend[i] <= 1'b1;
        cyl_flat[i*CYL_W +: CYL_W] <= '0;
        st0_flat[i*8 +: 8] <= 8'hC0 | 8'(i);
      end else if (hold) begin
        pend[i] <= 1'b0;
        cyl_flat[i*CYL_W +: CYL_W] <= '0;
      end else if (done_en && done_drv == DRV_W'(i)) begin
        pend[i] <= 1'b1;
        cyl_flat[i*CYL_W +: CYL_W] <= done_cyl;
        st0_flat[i*8 +: 8] <= done_st0;
      end else if (clr_en && clr_drv == DRV_W'(i)) begin
        pend[i] <= 1'b0;
      end
    end
  end

  a_r10_release_all_pending: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> &pend);
  a_r7_done_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en && !hold && !arm) |=> pend[$past(done_drv)]);
endmodule

// File: rtl/flop_seq.sv
module flop_seq
  import flop_cmd_pkg::*;
#(
  parameter int NDRV     = 4,
  parameter int CYL_W    = 8,
  parameter int STEP_CYC = 4,
  localparam int DRV_W = $clog2(NDRV),
  localparam int CNT_W = $clog2(((1 << CYL_W) - 1) * STEP_CYC + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold,
  input  logic                  arm,
  input  logic                  data_wr,
  input  logic                  data_rd,
  input  logic [7:0]            wdata,
  input  logic [NDRV-1:0]       pend,
  input  logic [NDRV*CYL_W-1:0] cyl_flat,
  input  logic [NDRV*8-1:0]     st0_flat,
  output logic [7:0]            res_byte,
  output logic [7:0]            msr,
  output logic [3:0]            srt,
  output logic [3:0]            hut,
  output logic [6:0]            hlt,
  output logic                  ndma,
  output logic                  fifo_on,
  output logic [3:0]            thresh,
  output logic                  impl_seek,
  output logic                  perr,
  output logic                  irq_flag,
  output logic                  done_en,
  output logic [DRV_W-1:0]      done_drv,
  output logic [CYL_W-1:0]      done_cyl,
  output logic [7:0]            done_st0,
  output logic                  clr_en,
  output logic [DRV_W-1:0]      clr_drv
);
  phase_e           phase;
  logic [7:0]       op_q, p0_q, res0_q, res1_q;
  logic [1:0]       pcnt_q, pneed_q;
  logic             ridx_q, rlen2_q, drain_q, head_q;
  logic [DRV_W-1:0] xdrv_q;
  logic [CYL_W-1:0] xtgt_q;
  logic [CNT_W-1:0] cnt_q;

  logic             wr_ok, is_idle, drain_act, bad_f, last_f, any_pend;
  logic [7:0]       op_f;
  logic [1:0]       need_f;
  logic [DRV_W-1:0] sel, mv_drv;
  logic [CYL_W-1:0] mv_tgt, mv_cur, mv_dist;

  assign is_idle   = phase == PH_IDLE;
  assign wr_ok     = data_wr && (is_idle || phase == PH_PARAM);
  assign drain_act = drain_q && |pend;
  assign op_f      = is_idle ? wdata : op_q;
  assign bad_f     = is_idle && (!op_known(wdata) || (drain_act && wdata != OP_SENSE));
  assign need_f    = bad_f ? 2'd0 : op_params(wdata);
  assign last_f    = is_idle ? (need_f == 2'd0) : (pcnt_q == pneed_q - 2'd1);

  always_comb begin
    any_pend = |pend;
    sel = '0;
    for (int i = NDRV - 1; i >= 0; i--) if (pend[i]) sel = DRV_W'(i);
  end

  // head-movement target, valid when the last parameter arrives
  assign mv_drv  = (op_f == OP_SEEK) ? p0_q[DRV_W-1:0] : wdata[DRV_W-1:0];
  assign mv_tgt  = (op_f == OP_SEEK) ? wdata[CYL_W-1:0] : '0;
  assign mv_cur  = cyl_flat[mv_drv*CYL_W +: CYL_W];
  assign mv_dist = (mv_tgt > mv_cur) ? mv_tgt - mv_cur : mv_cur - mv_tgt;

  assign done_en  = phase == PH_EXEC && cnt_q == '0 && !hold;
  assign done_drv = xdrv_q;
  assign done_cyl = xtgt_q;
  assign done_st0 = 8'h20 | {5'd0, head_q, 2'd0} | 8'(xdrv_q);
  assign clr_en   = wr_ok && last_f && op_f == OP_SENSE && !bad_f && any_pend;
  assign clr_drv  = sel;

  assign res_byte = ridx_q ? res1_q : res0_q;
  assign msr = {phase != PH_EXEC, phase == PH_RESULT,
                phase == PH_EXEC && ndma, !is_idle,
                (phase == PH_EXEC) ? 4'(4'd1 << xdrv_q) : 4'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; op_q <= '0; p0_q <= '0; res0_q <= '0; res1_q <= '0;
      pcnt_q <= '0; pneed_q <= '0; ridx_q <= 1'b0; rlen2_q <= 1'b0;
      drain_q <= 1'b0; head_q <= 1'b0; xdrv_q <= '0; xtgt_q <= '0; cnt_q <= '0;
      srt <= '0; hut <= '0; hlt <= '0; ndma <= 1'b0;
      fifo_on <= 1'b0; thresh <= '0; impl_seek <= 1'b0;
      perr <= 1'b0; irq_flag <= 1'b0;
    end else if (hold) begin
      phase <= PH_IDLE; ridx_q <= 1'b0;
      srt <= '0; hut <= '0; hlt <= '0; ndma <= 1'b0;
      fifo_on <= 1'b0; thresh <= '0;
      perr <= 1'b0;
      irq_flag <= arm;
      drain_q <= arm;
    end else begin
      if (drain_q && !any_pend) drain_q <= 1'b0;
      if (data_wr && !(is_idle || phase == PH_PARAM)) perr <= 1'b1;
      if (phase == PH_EXEC) begin
        if (done_en) begin
          phase <= PH_IDLE;
          irq_flag <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
      end
      if (phase == PH_RESULT && data_rd) begin
        irq_flag <= 1'b0;
        if (ridx_q == rlen2_q) begin
          phase <= PH_IDLE;
          ridx_q <= 1'b0;
        end else ridx_q <= 1'b1;
      end
      if (wr_ok) begin
        if (is_idle) begin
          op_q <= wdata; pcnt_q <= '0; pneed_q <= need_f;
        end else begin
          pcnt_q <= pcnt_q + 2'd1;
          if (pcnt_q == 2'd0) p0_q <= wdata;
          if (op_q == OP_CONFIG && pcnt_q == 2'd1) begin
            impl_seek <= wdata[6];
            fifo_on   <= !wdata[5];
            thresh    <= wdata[3:0];
          end
        end
        if (!last_f) phase <= PH_PARAM;
        else if (bad_f) begin
          res0_q <= BAD_BYTE; rlen2_q <= 1'b0; ridx_q <= 1'b0; phase <= PH_RESULT;
        end else begin
          case (op_f)
            OP_VERSION: begin
              res0_q <= ID_BYTE; rlen2_q <= 1'b0; ridx_q <= 1'b0; phase <= PH_RESULT;
            end
            OP_SENSE: begin
              irq_flag <= 1'b0;
              ridx_q <= 1'b0; phase <= PH_RESULT;
              if (any_pend) begin
                res0_q  <= st0_flat[sel*8 +: 8];
                res1_q  <= 8'(cyl_flat[sel*CYL_W +: CYL_W]);
                rlen2_q <= 1'b1;
              end else begin
                res0_q <= BAD_BYTE; rlen2_q <= 1'b0;
              end
            end
            OP_SPECIFY: begin
              srt <= p0_q[7:4]; hut <= p0_q[3:0];
              hlt <= wdata[7:1]; ndma <= wdata[0];
              phase <= PH_IDLE;
            end
            OP_SEEK, OP_RECAL: begin
              xdrv_q <= mv_drv; xtgt_q <= mv_tgt;
              head_q <= (op_f == OP_SEEK) ? p0_q[2] : 1'b0;
              cnt_q  <= CNT_W'(mv_dist) * CNT_W'(STEP_CYC);
              phase  <= PH_EXEC;
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  a_r4_version_result: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (wr_ok && is_idle && wdata == OP_VERSION && !drain_act) |=>
      (phase == PH_RESULT && res_byte == ID_BYTE));
  a_r2_last_read_exits: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (phase == PH_RESULT && data_rd && ridx_q == rlen2_q) |=> phase == PH_IDLE);
  a_r12_bad_write_flags: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (data_wr && (phase == PH_EXEC || phase == PH_RESULT)) |=> perr);
  a_r13_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (phase == PH_RESULT && data_rd) |=> !irq_flag);
  a_r11_drain_blocks: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (wr_ok && is_idle && drain_act && wdata != OP_SENSE) |=>
      (phase == PH_RESULT && res_byte == BAD_BYTE));
  a_r3_exec_no_request: assert property (@(posedge clk) disable iff (!rst_n || hold)
    (phase == PH_EXEC && !done_en) |=> !msr[7]);
endmodule

// File: rtl/flop_cmd_front.sv
module flop_cmd_front
  import flop_cmd_pkg::*;
#(
  parameter int NDRV     = 4,
  parameter int CYL_W    = 8,
  parameter int STEP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic [1:0] drv_sel,
  output logic [3:0] motor_on,
  output logic       ctl_in_reset,
  output logic [3:0] step_rate,
  output logic [3:0] unload_time,
  output logic [6:0] load_time,
  output logic       no_dma,
  output logic       fifo_on,
  output logic [3:0] fifo_thresh,
  output logic       implied_seek,
  output logic       proto_err
);
  localparam int DRV_W = $clog2(NDRV);

  logic [7:0] ctrl_q, msr, res_byte, done_st0;
  logic hold, arm, irq_flag, done_en, clr_en;
  logic [DRV_W-1:0] done_drv, clr_drv;
  logic [CYL_W-1:0] done_cyl;
  logic [NDRV-1:0] pend;
  logic [NDRV*CYL_W-1:0] cyl_flat;
  logic [NDRV*8-1:0] st0_flat;

  flop_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr && bus_addr == A_CTRL),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .hold(hold), .arm(arm));

  flop_drive_track #(.NDRV(NDRV), .CYL_W(CYL_W)) u_track (
    .clk(clk), .rst_n(rst_n), .hold(hold), .arm(arm),
    .done_en(done_en), .done_drv(done_drv), .done_cyl(done_cyl), .done_st0(done_st0),
    .clr_en(clr_en), .clr_drv(clr_drv),
    .cyl_flat(cyl_flat), .st0_flat(st0_flat), .pend(pend));

  flop_seq #(.NDRV(NDRV), .CYL_W(CYL_W), .STEP_CYC(STEP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(hold), .arm(arm),
    .data_wr(bus_wr && bus_addr == A_DATA), .data_rd(bus_rd && bus_addr == A_DATA),
    .wdata(bus_wdata), .pend(pend), .cyl_flat(cyl_flat), .st0_flat(st0_flat),
    .res_byte(res_byte), .msr(msr),
    .srt(step_rate), .hut(unload_time), .hlt(load_time), .ndma(no_dma),
    .fifo_on(fifo_on), .thresh(fifo_thresh), .impl_seek(implied_seek),
    .perr(proto_err), .irq_flag(irq_flag),
    .done_en(done_en), .done_drv(done_drv), .done_cyl(done_cyl), .done_st0(done_st0),
    .clr_en(clr_en), .clr_drv(clr_drv));

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = msr;
      A_DATA:  bus_rdata = (msr[7] && msr[6]) ? res_byte : 8'h00;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq          = irq_flag && ctrl_q[3];
  assign drv_sel      = ctrl_q[1:0];
  assign motor_on     = ctrl_q[7:4];
  assign ctl_in_reset = hold;

  a_r10_hold_clears_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> (!fifo_on && fifo_thresh == 4'd0 && !proto_err));
endmodule

// File: tb/flop_cmd_front_tb_top.sv
`timescale 1ns/1ps
module flop_cmd_front_tb_top;
  localparam int STEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic irq, ctl_in_reset, no_dma, fifo_on, implied_seek, proto_err;
  logic [1:0] drv_sel;
  logic [3:0] motor_on, step_rate, unload_time, fifo_thresh;
  logic [6:0] load_time;

  int nchk = 0, nerr = 0;
  int cyl_m[4];
  logic ndma_m = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flop_cmd_front #(.STEP_CYC(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .drv_sel(drv_sel),
    .motor_on(motor_on), .ctl_in_reset(ctl_in_reset), .step_rate(step_rate),
    .unload_time(unload_time), .load_time(load_time), .no_dma(no_dma),
    .fifo_on(fifo_on), .fifo_thresh(fifo_thresh), .implied_seek(implied_seek),
    .proto_err(proto_err));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd1, s);
      if (s[7]) return;
    end
    chk("R3 execution never ended", 0, 1);
  endtask

  function automatic int seek_st0(input int head, input int drv);
    return 32'h20 | (head << 2) | drv;
  endfunction

  task automatic sense_expect(input string req, input int st0, input int cyl);
    logic [7:0] d;
    wr(2'd2, 8'h08);
    rd(2'd2, d); chk({req, " sense ST0"}, d, st0);
    rd(2'd2, d); chk({req, " sense cylinder"}, d, cyl);
  endtask

  task automatic drain_all(input string req);
    for (int i = 0; i < 4; i++) sense_expect(req, 32'hC0 | i, 0);
    for (int i = 0; i < 4; i++) cyl_m[i] = 0;
  endtask

  task automatic seek(input int drv, input int head, input int cyl);
    wr(2'd2, 8'h0F); wr(2'd2, 8'((head << 2) | drv)); wr(2'd2, 8'(cyl));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 control reg", d, 0);
    rd(2'd1, d); chk("R1 status idle", d, 8'h80);
    chk("R1 held in reset", ctl_in_reset, 1);

    // release, R13 irq, R11 drain enforcement, R10 reset status
    wr(2'd0, 8'h0C);
    @(posedge clk); #1 chk("R13 irq after release", irq, 1);
    wr(2'd2, 8'h10); rd(2'd2, d); chk("R11 version blocked", d, 8'h80);
    sense_expect("R10", 32'hC0, 0);
    chk("R13 irq cleared by sense", irq, 0);
    for (int i = 1; i < 4; i++) sense_expect("R10", 32'hC0 | i, 0);
    wr(2'd2, 8'h08); rd(2'd2, d); chk("R8 sense none pending", d, 8'h80);
    rd(2'd1, d); chk("R2 idle after single result", d, 8'h80);

    // R2 / R4 version and unknown
    wr(2'd2, 8'h10); rd(2'd1, d); chk("R2 result phase status", d, 8'hD0);
    rd(2'd2, d); chk("R4 version byte", d, 8'h90);
    rd(2'd1, d); chk("R2 back to idle", d, 8'h80);
    wr(2'd2, 8'h1F); rd(2'd2, d); chk("R4 unknown command", d, 8'h80);

    // R5 specify, random values
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b1, b2;
      b1 = 8'($urandom); b2 = 8'($urandom);
      if (k == 3) b2[0] = 1'b1;
      wr(2'd2, 8'h03); rd(2'd1, d); chk("R2 awaiting params", d, 8'h90);
      wr(2'd2, b1); wr(2'd2, b2);
      rd(2'd1, d); chk("R5 no result phase", d, 8'h80);
      chk("R5 step rate", step_rate, b1[7:4]);
      chk("R5 unload", unload_time, b1[3:0]);
      chk("R5 load", load_time, b2[7:1]);
      chk("R5 no dma", no_dma, b2[0]);
      ndma_m = b2[0];
    end

    // R6 configure
    wr(2'd2, 8'h13); wr(2'd2, 8'h00); wr(2'd2, 8'h47); wr(2'd2, 8'h00);
    chk("R6 implied seek", implied_seek, 1);
    chk("R6 fifo on", fifo_on, 1);
    chk("R6 threshold", fifo_thresh, 7);

    // R7 exact timing, R3 status, R12 protocol error
    seek(2, 1, 40);
    repeat (40 * STEP) @(posedge clk);
    @(negedge clk); bus_addr = 2'd1; #1;
    chk("R3 exec status", bus_rdata, 8'h10 | (ndma_m ? 8'h20 : 8'h00) | 8'h04);
    @(posedge clk); #1 chk("R7 exec ended on time", bus_rdata[7], 1);
    chk("R13 irq at exec end", irq, 1);
    seek(1, 0, 9);
    wr(2'd2, 8'h55);
    chk("R12 proto error", proto_err, 1);
    wait_idle();
    cyl_m[2] = 40; cyl_m[1] = 9;
    sense_expect("R8 lowest first", seek_st0(0, 1), 9);
    sense_expect("R7 seek", seek_st0(1, 2), 40);

    // random seeks / recalibrates against model
    for (int k = 0; k < 30; k++) begin
      int dv, hd, cy;
      dv = int'($urandom_range(0, 3));
      hd = int'($urandom_range(0, 1));
      cy = int'($urandom_range(0, 79));
      if ($urandom_range(0, 3) == 0) begin
        wr(2'd2, 8'h07); wr(2'd2, 8'(dv)); hd = 0; cy = 0;
      end else seek(dv, hd, cy);
      wait_idle();
      cyl_m[dv] = cy;
      sense_expect("R7 random", seek_st0(hd, dv), cyl_m[dv]);
    end

    // R9 control register
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = 8'($urandom) | 8'h04;
      wr(2'd0, v);
      rd(2'd0, d); chk("R9 readback", d, v);
      chk("R9 drive select", drv_sel, v[1:0]);
      chk("R9 motors", motor_on, v[7:4]);
    end

    // R10 held reset
    wr(2'd0, 8'h08);
    repeat (2) @(posedge clk); #1;
    chk("R10 fifo off", fifo_on, 0);
    chk("R10 threshold", fifo_thresh, 0);
    chk("R10 step rate cleared", step_rate, 0);
    chk("R10 implied seek kept", implied_seek, 1);
    chk("R10 proto error cleared", proto_err, 0);
    rd(2'd1, d); chk("R1 status in reset", d, 8'h80);
    wr(2'd0, 8'h0C); drain_all("R10");

    // coincidence: zero-step seek ends in the cycle reset is entered
    seek(3, 0, 0);
    wr(2'd0, 8'h08);
    repeat (3) @(posedge clk);
    wr(2'd0, 8'h0C); drain_all("R10 coincide");

    // R13 irq gated by enable bit
    wr(2'd0, 8'h00); wr(2'd0, 8'h04);
    @(posedge clk); #1 chk("R13 irq masked", irq, 0);
    wr(2'd0, 8'h0C);
    @(posedge clk); #1 chk("R13 irq unmasked", irq, 1);
    drain_all("R11");
    wr(2'd2, 8'h10); rd(2'd2, d); chk("R11 normal after drain", d, 8'h90);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule